// File: doc/BRIEF.md
# Data-Break Disk Transfer Engine

This block copies 12-bit words between a word-addressed disk image and main memory. It follows a three-cycle data-break pattern. The transfer's word count and current memory address are not held in registers. They live in two fixed memory words, 07750 and 07751 (octal), in field 0. For every word the engine reads each of these locations, adds one, and writes it back. It then performs the data cycle at the freshly incremented address. A transfer ends when the count wraps to zero, or earlier on an error.

A host starts a transfer with a single-cycle strobe. The strobe carries the direction, a 20-bit starting disk address, a 3-bit memory field and a burst select. The write-lock mask, the disk capacity and the installed memory size are static configuration inputs. In burst mode words follow one another back to back. Otherwise the engine waits a fixed number of idle cycles between words. The running disk address, two error flags and a done flag are visible at all times.

Top module: `dbreak_xfer`

## Requirements
- R1: Each word starts with four memory handshakes, in this order: read location 07750, write it back plus one (mod 4096), read location 07751, write it back plus one (mod 4096). Both locations are in field 0. A request holds its address, direction and write data until `mem_ready` is seen high at a clock edge.
- R2: The data cycle uses the 15-bit address {field, incremented address}. The 12-bit part wraps from 07777 to 0000 without changing the field.
- R3: With `start_wr`=0 (disk to memory), the disk word at the current disk address is written to memory only when the physical address is below `mem_limit`. Otherwise that word has no data cycle.
- R4: With `start_wr`=1 (memory to disk), the lock index is {disk address bits 19:18, bits 16:14} (5 bits) and selects a bit of `lock_mask`. If that bit is set, no data read and no disk write take place and `err_wlock` is set. If it is clear, memory is read and the word is written to the disk at the current address.
- R5: Before each word, a disk address at or above `capacity` sets `err_nxd` and ends the transfer at once. No memory access is made and the disk address is left unchanged.
- R6: The disk address advances by one after every word, including a locked one, as a 21-bit value. A carry out of bit 19 reaches bit 20.
- R7: In burst mode the engine keeps going until the count reaches zero, even after a write-lock error. The next word's count read is issued two cycles after the cycle in which the previous word's last access completed.
- R8: Outside burst mode the engine continues only while the count is nonzero and no error flag is set. Between words it inserts exactly `GAP_CYCLES` extra idle cycles.
- R9: `done` is high when idle. An accepted start clears `done` and both error flags on the next edge. `done` rises again when the transfer ends.
- R10: A start strobe that arrives while a transfer is running has no effect.
- R11: After reset `done`=1, both errors are 0, the disk address is 0 and no request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| start_wr | input | 1 | Direction: 1 = memory to disk, 0 = disk to memory |
| start_dadr | input | 20 | Starting disk word address |
| mem_ext | input | 3 | Memory field for data cycles |
| burst | input | 1 | 1 = back-to-back words |
| lock_mask | input | 32 | Write-lock bit per lock index |
| capacity | input | 21 | First nonexistent disk address |
| mem_limit | input | 16 | Number of installed memory words |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory handshake complete |
| dsk_en | output | 1 | Disk buffer access |
| dsk_we | output | 1 | Disk buffer write |
| dsk_addr | output | 21 | Disk buffer word address |
| dsk_wdata | output | 12 | Disk write data |
| dsk_rdata | input | 12 | Disk read data for `dsk_addr`, same cycle |
| dadr | output | 21 | Current disk address |
| err_wlock | output | 1 | Write-lock error |
| err_nxd | output | 1 | Nonexistent-disk error |
| done | output | 1 | Idle / transfer finished |

## Verification
The bench steps the memory address across 07777 in field 1. An engine that let the carry reach the field would write into field 2. It runs a burst write across a lock boundary, where a design that stopped at the first locked word would leave the count nonzero and the tail of the disk unwritten. It runs the same write without burst, which must stop right after the locked word. Further cases cover a capacity hit in mid-transfer and at the very first word, a disk-address carry into bit 20, a read into a field that does not exist (any data write there is flagged), and lock indices that differ only in bit 17 or bit 19. Word spacing is measured in cycles in both modes, so a missing or extra gap cycle shows up as a timing mismatch.

// File: rtl/dbk_pkg.sv
// Shared types of the data-break transfer engine.
package dbk_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK,
        ST_WC_RD,
        ST_WC_WR,
        ST_MA_RD,
        ST_MA_WR,
        ST_DATA,
        ST_DSKW,
        ST_NEXT,
        ST_GAP
    } dbk_state_e;
endpackage

// File: rtl/dbk_lock_lookup.sv
// Write-lock lookup: builds the lock index from disk address bits 19:18
// (upper) and 16:14 (lower) and returns the selected mask bit.
// Assumes DA_W >= 20 and a 32-entry mask.
module dbk_lock_lookup #(
    parameter int DA_W   = 21,
    parameter int LOCK_N = 32,
    parameter int IDX_W  = $clog2(LOCK_N)
) (
    input  logic [DA_W-1:0]   dadr,
    input  logic [LOCK_N-1:0] mask,
    output logic              lock_hit
);
    logic [IDX_W-1:0] idx;

    // index formation and mask select
    always_comb begin
        idx      = {dadr[19:18], dadr[16:14]};
        lock_hit = mask[idx];
    end
endmodule

// File: rtl/dbk_phys_addr.sv
// Physical address former: prefixes the field to the 12-bit address and
// reports whether that word is installed. Assumes limit counts words.
module dbk_phys_addr #(
    parameter int WORD_W = 12,
    parameter int EXT_W  = 3,
    parameter int PA_W   = EXT_W + WORD_W
) (
    input  logic [EXT_W-1:0]  ext,
    input  logic [WORD_W-1:0] ofs,
    input  logic [PA_W:0]     limit,
    output logic [PA_W-1:0]   paddr,
    output logic              present
);
    // concatenation and presence compare
    always_comb begin
        paddr   = {ext, ofs};
        present = ({1'b0, paddr} < limit);
    end
endmodule

// File: rtl/dbk_gap_timer.sv
// Inter-word gap timer: load starts a window of GAP cycles; expired is
// high in the last one. Assumes GAP >= 1.
module dbk_gap_timer #(
    parameter int GAP = 6,
    parameter int CW  = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    // countdown register
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= CW'(GAP - 1);
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // expiry flag
    assign expired = (cnt == '0);
endmodule

// File: rtl/dbreak_xfer.sv
// Data-break disk transfer engine. Per word: pre-increment the count and
// address words held in memory, then one data cycle. Assumes the memory
// port returns read data together with ready and that the disk buffer
// returns data for dsk_addr within the same cycle.
module dbreak_xfer
    import dbk_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter int EXT_W      = 3,
    parameter int DA_IN_W    = 20,
    parameter int DA_W       = 21,
    parameter int LOCK_N     = 32,
    parameter int GAP_CYCLES = 6,
    parameter int PA_W       = EXT_W + WORD_W,
    parameter logic [WORD_W-1:0] WC_LOC = 12'o7750
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_wr,
    input  logic [DA_IN_W-1:0] start_dadr,
    input  logic [EXT_W-1:0]   mem_ext,
    input  logic               burst,
    input  logic [LOCK_N-1:0]  lock_mask,
    input  logic [DA_W-1:0]    capacity,
    input  logic [PA_W:0]      mem_limit,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PA_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    output logic               dsk_en,
    output logic               dsk_we,
    output logic [DA_W-1:0]    dsk_addr,
    output logic [WORD_W-1:0]  dsk_wdata,
    input  logic [WORD_W-1:0]  dsk_rdata,
    output logic [DA_W-1:0]    dadr,
    output logic               err_wlock,
    output logic               err_nxd,
    output logic               done
);
    localparam logic [WORD_W-1:0] MA_LOC  = WC_LOC + 1'b1;
    localparam logic [PA_W-1:0]   WC_ADDR = {{EXT_W{1'b0}}, WC_LOC};
    localparam logic [PA_W-1:0]   MA_ADDR = {{EXT_W{1'b0}}, MA_LOC};

    dbk_state_e        state;
    logic              func_wr, burst_q, err_wl_q, err_nx_q, done_q;
    logic [EXT_W-1:0]  ext_q;
    logic [DA_W-1:0]   da_q;
    logic [WORD_W-1:0] wc_q, ma_q, data_q;
    logic [PA_W-1:0]   paddr;
    logic              pa_ok, lock_hit, gap_exp, gap_load;

    dbk_lock_lookup #(.DA_W(DA_W), .LOCK_N(LOCK_N)) u_lock (
        .dadr(da_q), .mask(lock_mask), .lock_hit(lock_hit));

    dbk_phys_addr #(.WORD_W(WORD_W), .EXT_W(EXT_W), .PA_W(PA_W)) u_pa (
        .ext(ext_q), .ofs(ma_q), .limit(mem_limit),
        .paddr(paddr), .present(pa_ok));

    dbk_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .run(state == ST_GAP), .expired(gap_exp));

    // gap timer is loaded when a non-burst word ends with more to do
    assign gap_load = (state == ST_NEXT) && !burst_q && (wc_q != '0)
                      && !err_wl_q && !err_nx_q;

    // port drive per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        dsk_en    = 1'b0;
        dsk_we    = 1'b0;
        dsk_wdata = data_q;
        case (state)
            ST_WC_RD: begin mem_req = 1'b1; mem_addr = WC_ADDR; end
            ST_WC_WR: begin mem_req = 1'b1; mem_we = 1'b1;
                            mem_addr = WC_ADDR; mem_wdata = wc_q; end
            ST_MA_RD: begin mem_req = 1'b1; mem_addr = MA_ADDR; end
            ST_MA_WR: begin mem_req = 1'b1; mem_we = 1'b1;
                            mem_addr = MA_ADDR; mem_wdata = ma_q; end
            ST_DATA: begin
                mem_addr = paddr;
                if (!func_wr) begin
                    mem_req   = pa_ok;
                    mem_we    = pa_ok;
                    mem_wdata = dsk_rdata;
                    dsk_en    = pa_ok;
                end else begin
                    mem_req = !lock_hit;
                end
            end
            ST_DSKW: begin dsk_en = 1'b1; dsk_we = 1'b1; end
            default: ;
        endcase
    end

    // sequencer and transfer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            func_wr  <= 1'b0;
            burst_q  <= 1'b0;
            ext_q    <= '0;
            da_q     <= '0;
            wc_q     <= '0;
            ma_q     <= '0;
            data_q   <= '0;
            err_wl_q <= 1'b0;
            err_nx_q <= 1'b0;
            done_q   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    func_wr  <= start_wr;
                    burst_q  <= burst;
                    ext_q    <= mem_ext;
                    da_q     <= DA_W'(start_dadr);
                    err_wl_q <= 1'b0;
                    err_nx_q <= 1'b0;
                    done_q   <= 1'b0;
                    state    <= ST_CHK;
                end
                ST_CHK: if (da_q >= capacity) begin
                    err_nx_q <= 1'b1;
                    done_q   <= 1'b1;
                    state    <= ST_IDLE;
                end else begin
                    state <= ST_WC_RD;
                end
                ST_WC_RD: if (mem_ready) begin
                    wc_q  <= mem_rdata + 1'b1;
                    state <= ST_WC_WR;
                end
                ST_WC_WR: if (mem_ready) state <= ST_MA_RD;
                ST_MA_RD: if (mem_ready) begin
                    ma_q  <= mem_rdata + 1'b1;
                    state <= ST_MA_WR;
                end
                ST_MA_WR: if (mem_ready) state <= ST_DATA;
                ST_DATA: begin
                    if (!func_wr) begin
                        if (!pa_ok || mem_ready) state <= ST_NEXT;
                    end else if (lock_hit) begin
                        err_wl_q <= 1'b1;
                        state    <= ST_NEXT;
                    end else if (mem_ready) begin
                        data_q <= mem_rdata;
                        state  <= ST_DSKW;
                    end
                end
                ST_DSKW: state <= ST_NEXT;
                ST_NEXT: begin
                    da_q <= da_q + 1'b1;
                    if (burst_q && wc_q != '0) begin
                        state <= ST_CHK;
                    end else if (gap_load) begin
                        state <= ST_GAP;
                    end else begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_GAP: if (gap_exp) state <= ST_CHK;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign dadr      = da_q;
    assign dsk_addr  = da_q;
    assign err_wlock = err_wl_q;
    assign err_nxd   = err_nx_q;
    assign done      = done_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R1
    AST_DATA_WR_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && mem_req && mem_we) |-> pa_ok); // R3
    AST_NO_LOCKED_DISK_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_en && dsk_we) |-> !lock_hit); // R4
    AST_NXD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_nxd) |-> (done && !mem_req && !dsk_en)); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !dsk_en)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && start) |=> (func_wr == $past(func_wr) && ext_q == $past(ext_q))); // R10
endmodule

// File: tb/dbreak_xfer_tb_top.sv
`timescale 1ns/1ps
module dbreak_xfer_tb_top;
    localparam int GAP   = 6;
    localparam int WCL   = 'o7750;
    localparam int MAL   = 'o7751;
    localparam int MLIM  = 8192;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, start_wr = 1'b0, burst = 1'b0;
    logic [19:0] start_dadr = '0;
    logic [2:0]  mem_ext = '0;
    logic [31:0] lock_mask = '0;
    logic [20:0] capacity = '0;
    logic [15:0] mem_limit = 16'(MLIM);
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata, mem_rdata = '0;
    logic        dsk_en, dsk_we;
    logic [20:0] dsk_addr, dadr;
    logic [11:0] dsk_wdata, dsk_rdata = '0;
    logic        err_wlock, err_nxd, done;

    always #2.5 clk = ~clk;

    dbreak_xfer #(.GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
        .start_dadr(start_dadr), .mem_ext(mem_ext), .burst(burst),
        .lock_mask(lock_mask), .capacity(capacity), .mem_limit(mem_limit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dsk_en(dsk_en), .dsk_we(dsk_we), .dsk_addr(dsk_addr),
        .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata),
        .dadr(dadr), .err_wlock(err_wlock), .err_nxd(err_nxd), .done(done));

    int n_cmp = 0, n_bad = 0, cyc = 0, lat = 0, wait_n = 0;
    int bmem [MLIM];
    int rmem [MLIM];
    int bdsk [int];
    int rdsk [int];
    int q_kind[$], q_addr[$], q_data[$];
    string q_tag[$];
    int wc_cyc[$];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int dpat(int a);
        return (a * 37 + 5) & 'hFFF;
    endfunction
    function automatic int bdval(int a);
        return bdsk.exists(a) ? bdsk[a] : dpat(a);
    endfunction
    function automatic int rdval(int a);
        return rdsk.exists(a) ? rdsk[a] : dpat(a);
    endfunction
    function automatic void push(int k, int a, int d, string t);
        q_kind.push_back(k); q_addr.push_back(a);
        q_data.push_back(d); q_tag.push_back(t);
    endfunction

    // observed access against the expected stream (kind 0 mem rd, 1 mem wr, 2 disk wr)
    task automatic observe(int k, int a, int d);
        int ek, ea, ed; string et;
        if (q_kind.size() == 0) begin
            chk(1'b0, "R1", "unexpected access addr", a, -1);
        end else begin
            ek = q_kind.pop_front(); ea = q_addr.pop_front();
            ed = q_data.pop_front(); et = q_tag.pop_front();
            chk(k == ek && a == ea && (k == 0 || d == ed), et,
                $sformatf("access kind %0d/%0d data %0h/%0h addr", k, ek, d, ed), a, ea);
        end
    endtask

    // memory and disk models, sampled away from the clock edge
    always @(negedge clk) begin
        bit rdy;
        cyc++;
        rdy = mem_req && (wait_n == lat);
        wait_n = (rdy || !mem_req) ? 0 : wait_n + 1;
        mem_ready = rdy;
        if (rdy) begin
            if (mem_we) begin
                observe(1, int'(mem_addr), int'(mem_wdata));
                if (int'(mem_addr) < MLIM) bmem[int'(mem_addr)] = int'(mem_wdata);
            end else begin
                observe(0, int'(mem_addr), 0);
                if (int'(mem_addr) == WCL) wc_cyc.push_back(cyc);
                mem_rdata = (int'(mem_addr) < MLIM) ? 12'(bmem[int'(mem_addr)]) : 12'h000;
            end
        end
        if (dsk_en && dsk_we) begin
            observe(2, int'(dsk_addr), int'(dsk_wdata));
            bdsk[int'(dsk_addr)] = int'(dsk_wdata);
        end
        dsk_rdata = 12'(bdval(int'(dsk_addr)));
        if (cyc == WD_LIMIT) begin
            chk(1'b0, "R9", "watchdog expired at cycle", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // behavioural reference of one transfer
    task automatic ref_run(bit wr, int da0, int ext, bit bst, logic [31:0] lk, int cap,
                           output int da_f, output bit wl, output bit nx);
        int da, wc, ma, pa, d, idx;
        da = da0; wl = 0; nx = 0;
        while (1) begin
            if (da >= cap) begin nx = 1; break; end
            wc = (rmem[WCL] + 1) % 4096;
            push(0, WCL, 0, "R1"); push(1, WCL, wc, "R1"); rmem[WCL] = wc;
            ma = (rmem[MAL] + 1) % 4096;
            push(0, MAL, 0, "R1"); push(1, MAL, ma, "R1"); rmem[MAL] = ma;
            pa = ext * 4096 + ma;
            if (!wr) begin
                if (pa < MLIM) begin d = rdval(da); push(1, pa, d, "R3"); rmem[pa] = d; end
            end else begin
                idx = ((da >> 18) & 3) * 8 + ((da >> 14) & 7);
                if (lk[idx]) wl = 1;
                else begin
                    d = (pa < MLIM) ? rmem[pa] : 0;
                    push(0, pa, 0, "R4"); push(2, da, d, "R4"); rdsk[da] = d;
                end
            end
            da = (da + 1) % (1 << 21);
            if (bst) begin if (wc == 0) break; end
            else if (wc == 0 || wl) break;
        end
        da_f = da;
    endtask

    task automatic xfer(string tg, bit wr, int da0, int ext, bit bst, int wc0, int ma0,
                        logic [31:0] lk, int cap, int l, bit poke);
        int exp_da, t, bad;
        bit exp_wl, exp_nx;
        lat = l;
        bmem[WCL] = wc0; rmem[WCL] = wc0; bmem[MAL] = ma0; rmem[MAL] = ma0;
        lock_mask = lk; capacity = 21'(cap);
        q_kind.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
        wc_cyc.delete();
        ref_run(wr, da0, ext, bst, lk, cap, exp_da, exp_wl, exp_nx);
        @(negedge clk);
        start = 1'b1; start_wr = wr; start_dadr = 20'(da0); mem_ext = 3'(ext); burst = bst;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0 && err_wlock == 1'b0 && err_nxd == 1'b0, "R9",
            {tg, " done/errors after start"}, {done, err_wlock, err_nxd}, 0);
        if (poke) begin
            repeat (15) @(negedge clk);
            start = 1'b1; start_wr = !wr; start_dadr = 20'h00123;
            mem_ext = 3'(ext + 1); burst = !bst;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R9", {tg, " done at end"}, done, 1);
        chk(q_kind.size() == 0, "R1", {tg, " accesses missing"}, q_kind.size(), 0);
        chk(int'(dadr) == exp_da, "R6", {tg, " final disk address"}, dadr, exp_da);
        chk(err_wlock == exp_wl, "R4", {tg, " write-lock error"}, err_wlock, exp_wl);
        chk(err_nxd == exp_nx, "R5", {tg, " nonexistent-disk error"}, err_nxd, exp_nx);
        bad = 0;
        for (int i = 0; i < MLIM; i++) if (bmem[i] != rmem[i]) bad++;
        chk(bad == 0, poke ? "R10" : "R2", {tg, " memory words differing"}, bad, 0);
        bad = (bdsk.size() != rdsk.size()) ? 1 : 0;
        foreach (rdsk[k]) if (!bdsk.exists(k) || bdsk[k] != rdsk[k]) bad++;
        chk(bad == 0, "R4", {tg, " disk words differing"}, bad, 0);
    endtask

    task automatic spacing(string tag, int expv);
        for (int i = 1; i < wc_cyc.size(); i++)
            chk(wc_cyc[i] - wc_cyc[i-1] == expv, tag, "word spacing in cycles",
                wc_cyc[i] - wc_cyc[i-1], expv);
    endtask

    initial begin
        for (int i = 0; i < MLIM; i++) begin bmem[i] = (i * 5 + 1) & 'hFFF; rmem[i] = bmem[i]; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(done && !err_wlock && !err_nxd && dadr == '0 && !mem_req && !dsk_en, "R11",
            "reset state", {done, err_wlock, err_nxd, mem_req, dsk_en}, 5'b10000);

        // R1 R2 R3 R7: burst read into field 1
        xfer("T1", 0, 'h01230, 1, 1, 'o7774, 'o0177, 0, 'h40000, 1, 0);
        spacing("R7", 12);
        // R8: same without burst, gap inserted
        xfer("T2", 0, 'h02000, 1, 0, 'o7775, 'o0400, 0, 'h40000, 1, 0);
        spacing("R8", 12 + GAP);
        // R3: field beyond installed memory, no data cycles
        xfer("T3", 0, 'h00100, 3, 1, 'o7776, 'o1000, 0, 'h40000, 0, 0);
        // R2: address wraps inside field 1
        xfer("T4", 0, 'h00200, 1, 1, 'o7775, 'o7776, 0, 'h40000, 0, 0);
        spacing("R7", 7);
        // R4: unlocked write, slow memory
        xfer("T5", 1, 'h00500, 0, 0, 'o7775, 'o1000, 0, 'h40000, 2, 0);
        // R7: burst continues past lock boundary
        xfer("T6", 1, 'h03FFE, 0, 1, 'o7774, 'o1100, 32'h2, 'h40000, 1, 0);
        // R8: non-burst stops after locked word
        xfer("T7", 1, 'h03FFE, 0, 0, 'o7774, 'o1200, 32'h2, 'h40000, 1, 0);
        // R4: bit 17 not part of index
        xfer("T8", 1, 'h20000, 0, 1, 'o7777, 'o1300, 32'h1, 'h100000, 0, 0);
        // R4: bit 19 and bit 14 give index 17
        xfer("T9", 1, 'h84000, 0, 1, 'o7777, 'o1310, 32'h0002_0000, 'h100000, 0, 0);
        xfer("T10", 1, 'h84000, 0, 1, 'o7777, 'o1320, ~32'h0002_0000, 'h100000, 0, 0);
        // R5: capacity reached mid-transfer, then at the first word
        xfer("T11", 0, 'h07FFE, 0, 1, 'o7773, 'o1400, 0, 'h8000, 0, 0);
        xfer("T12", 0, 'h08000, 0, 1, 'o7773, 'o1500, 0, 'h8000, 0, 0);
        // R6: carry into bit 20
        xfer("T13", 0, 'hFFFFF, 0, 1, 'o7776, 'o1600, 0, 'h100004, 0, 0);
        // R10: start strobe during a running transfer
        xfer("T14", 0, 'h00700, 0, 0, 'o7774, 'o1700, 0, 'h40000, 1, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule